// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside the command decoder of a synchronous DRAM model or controller and produces, beat by beat, the column address that a read or write burst touches. A small mode register holds the programmed burst length, burst order, CAS latency field and a single-write override. A start strobe launches a burst from a given column. Each advance strobe steps to the next beat. A stop strobe abandons the burst, which is what a precharge or a burst terminate command does to it.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size. In sequential order the beats count upward and wrap inside the block. In interleaved order each beat XORs its index into the low bits of the start column. A full-page burst walks through all 512 columns, wrapping from 511 to 0, until it is stopped. Row, bank, data path, masking and the read-data delay belong to other blocks. The CAS latency field is only held and exported.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o, last_o and mode_err_o are 0, cas_lat_o is 0, and the mode register holds all zeros, which gives sequential order and length 1.
- R2: A start_i pulse makes valid_o 1 on the next cycle, with col_o equal to the start column (beat 0).
- R3: mode_i[2:0] sets the length: 000 is 1, 001 is 2, 010 is 4, 011 is 8 and 111 is full page. The codes 100, 101 and 110 set mode_err_o and act as length 1.
- R4: With mode_i[3]=0 (sequential), beat k has low bits (start + k) mod L, and the column bits above the L-sized block pass through unchanged.
- R5: With mode_i[3]=1 (interleaved), beat k has low bits equal to the start column's low bits XOR k, and the upper bits pass through unchanged.
- R6: In full-page mode, column = (start + k) mod 512. The burst never ends on its own, and last_o stays 0.
- R7: Full-page length combined with interleaved order sets mode_err_o and acts as length 1.
- R8: When mode_i[7]=1, a burst started with start_wr_i=1 is one beat long. A burst started with start_wr_i=0 keeps the programmed length.
- R9: last_o is 1 exactly on the final beat of a fixed burst. An advance on that beat makes valid_o 0 on the next cycle.
- R10: stop_i without start_i makes valid_o 0 on the next cycle.
- R11: start_i on any cycle, including during a burst and together with stop_i or adv_i, restarts from the new column and abandons the previous burst.
- R12: Without adv_i, the beat and col_o hold. adv_i while no burst is active has no effect.
- R13: mode_ld_i writes mode_i into the register, and the new value acts from the next cycle. cas_lat_o shows the loaded bits 6:4 (010 = 2, 011 = 3). A start in the same cycle as a load uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ld_i | input | 1 | Load mode_i into the mode register |
| mode_i | input | 8 | Length [2:0], order [3], CAS latency [6:4], single write [7] |
| start_i | input | 1 | Begin a burst |
| start_wr_i | input | 1 | The burst being started is a write |
| start_col_i | input | 9 | Starting column |
| adv_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | Abandon the current burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A burst beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |
| mode_err_o | output | 1 | Programmed length/order combination is reserved or illegal |
| cas_lat_o | output | 3 | Programmed CAS latency field |

## Verification
The assertions assume the strobes are clean and synchronous, and that start_i has priority over stop_i, which has priority over adv_i. They assume nothing about the spacing between commands. The bench therefore drives every input combination at the falling edge: directed runs for each length, order and error code, then a long random run in which loads, restarts, stops and advances land in any cycle, including a load and a start in the same cycle. A behavioural model of integers and modulo arithmetic predicts every output on every cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_LOG_W = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic                 full_page;
    burst_order_e         order;
    logic [LEN_LOG_W-1:0] len_log;
  } burst_cfg_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int LEN_LSB  = 0,
  parameter int TYPE_BIT = 3,
  parameter int CL_LSB   = 4,
  parameter int CL_W     = 3,
  parameter int SW_BIT   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [MODE_W-1:0] mode_i,
  output burst_cfg_t        cfg_o,
  output logic              single_wr_o,
  output logic              err_o,
  output logic [CL_W-1:0]   cas_o
);
  logic [MODE_W-1:0] mode_q;
  logic [2:0]        len_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (ld_i) mode_q <= mode_i;
  end

  assign len_code    = mode_q[LEN_LSB +: 3];
  assign single_wr_o = mode_q[SW_BIT];
  assign cas_o       = mode_q[CL_LSB +: CL_W];

  always_comb begin
    cfg_o.full_page = 1'b0;
    cfg_o.order     = burst_order_e'(mode_q[TYPE_BIT]);
    cfg_o.len_log   = '0;
    err_o           = 1'b0;
    unique case (len_code)
      3'b000: cfg_o.len_log = LEN_LOG_W'(0);
      3'b001: cfg_o.len_log = LEN_LOG_W'(1);
      3'b010: cfg_o.len_log = LEN_LOG_W'(2);
      3'b011: cfg_o.len_log = LEN_LOG_W'(3);
      3'b111: begin
        if (cfg_o.order == ORD_ILV) err_o = 1'b1;  // endless burst only in sequential order
        else                        cfg_o.full_page = 1'b1;
      end
      default: err_o = 1'b1;
    endcase
  end

  // R13
  cas_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cas_o == $past(mode_i[CL_LSB +: CL_W]));

  // R7
  fp_ilv_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o.full_page |-> !err_o && cfg_o.order == ORD_SEQ);
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_cfg_t       cfg_i,
  input  logic             single_wr_i,
  input  logic             adv_i,
  input  logic             stop_i,
  output logic             valid_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output burst_cfg_t       cfg_o,
  output logic             last_o
);
  logic             valid_q;
  logic [COL_W-1:0] base_q, beat_q, final_beat;
  burst_cfg_t       cfg_q, cfg_start;

  always_comb begin
    cfg_start = cfg_i;
    if (wr_i && single_wr_i) begin
      cfg_start.full_page = 1'b0;
      cfg_start.len_log   = '0;
    end
  end

  assign final_beat = (COL_W'(1) << cfg_q.len_log) - COL_W'(1);
  assign last_o     = valid_q && !cfg_q.full_page && (beat_q == final_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      cfg_q   <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      base_q  <= start_col_i;
      beat_q  <= '0;
      cfg_q   <= cfg_start;
    end else if (stop_i) begin
      valid_q <= 1'b0;
    end else if (adv_i && valid_q) begin
      if (last_o) valid_q <= 1'b0;
      else        beat_q  <= beat_q + COL_W'(1);  // full page wraps at 2**COL_W
    end
  end

  assign valid_o = valid_q;
  assign base_o  = base_q;
  assign beat_o  = beat_q;
  assign cfg_o   = cfg_q;

  // R2
  start_beat0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && beat_o == '0);

  // R10
  stop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o);

  // R9
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && adv_i && !start_i && !stop_i |=> !valid_o);

  // R6
  fp_no_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cfg_o.full_page |-> !last_o);

  // R12
  hold_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !adv_i && !start_i && !stop_i |=> valid_o && $stable(beat_o));

  // R12
  idle_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o);
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] blk_mask, low;

  assign blk_mask = cfg_i.full_page ? '1 : (COL_W'(1) << cfg_i.len_log) - COL_W'(1);
  assign low      = (cfg_i.order == ORD_ILV) ? (base_i ^ beat_i) : (base_i + beat_i);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = blk_mask[b] ? low[b] : base_i[b];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 8,
  parameter int CL_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_ld_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic              start_wr_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              adv_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              mode_err_o,
  output logic [CL_W-1:0]   cas_lat_o
);
  burst_cfg_t       mode_cfg, run_cfg;
  logic             single_wr;
  logic [COL_W-1:0] base, beat;

  burst_mode_reg #(.MODE_W(MODE_W), .CL_W(CL_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (mode_ld_i),
    .mode_i     (mode_i),
    .cfg_o      (mode_cfg),
    .single_wr_o(single_wr),
    .err_o      (mode_err_o),
    .cas_o      (cas_lat_o)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wr_i       (start_wr_i),
    .start_col_i(start_col_i),
    .cfg_i      (mode_cfg),
    .single_wr_i(single_wr),
    .adv_i      (adv_i),
    .stop_i     (stop_i),
    .valid_o    (valid_o),
    .base_o     (base),
    .beat_o     (beat),
    .cfg_o      (run_cfg),
    .last_o     (last_o)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i(base),
    .beat_i(beat),
    .cfg_i (run_cfg),
    .col_o (col_o)
  );

  // R2
  start_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_o == $past(start_col_i));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_ld = 1'b0;
  logic [7:0] mode_v = '0;
  logic       start = 1'b0, start_wr = 1'b0, adv = 1'b0, stop = 1'b0;
  logic [8:0] start_col = '0;
  logic [8:0] col;
  logic       valid, last, err;
  logic [2:0] cas;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // reference state
  int m_mode = 0;
  bit m_valid = 0;
  int m_beat = 0, m_base = 0, m_n = 1;  // m_n == 0 means full page
  bit m_il = 0;

  always #10 clk = ~clk;

  burst_col_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_ld_i(mode_ld), .mode_i(mode_v),
    .start_i(start), .start_wr_i(start_wr), .start_col_i(start_col),
    .adv_i(adv), .stop_i(stop), .col_o(col), .valid_o(valid),
    .last_o(last), .mode_err_o(err), .cas_lat_o(cas)
  );

  function automatic int len_of(int md, output bit bad);
    int code = md % 8;
    bit il = ((md / 8) % 2) == 1;
    bad = 0;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: if (il) begin bad = 1; return 1; end else return 0;
      default: begin bad = 1; return 1; end
    endcase
  endfunction

  function automatic int exp_col();
    int off, blk;
    if (m_n == 0) return (m_base + m_beat) % 512;
    off = m_base % m_n;
    blk = m_base - off;
    if (m_il) return blk + (off ^ m_beat);
    return blk + ((off + m_beat) % m_n);
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit bad;
    int n = len_of(m_mode, bad);
    chk("valid", int'(valid), int'(m_valid));
    chk("last", int'(last), int'(m_valid && m_n != 0 && m_beat == m_n - 1));
    chk("err", int'(err), int'(bad));
    chk("cas", int'(cas), (m_mode / 16) % 8);
    if (m_valid) chk("col", int'(col), exp_col());
  endtask

  // drive at a falling edge, advance the model, then check at the next falling edge
  task automatic cyc(bit ld, int mv, bit st, bit wr, int c, bit a, bit sp);
    bit bad;
    mode_ld = ld; mode_v = 8'(mv); start = st; start_wr = wr;
    start_col = 9'(c); adv = a; stop = sp;
    if (st) begin
      m_n = len_of(m_mode, bad);
      m_il = ((m_mode / 8) % 2) == 1;
      if (wr && m_mode >= 128) m_n = 1;
      m_valid = 1; m_beat = 0; m_base = c;
    end else if (sp) begin
      m_valid = 0;
    end else if (a && m_valid) begin
      if (m_n != 0 && m_beat == m_n - 1) m_valid = 0;
      else m_beat = (m_beat + 1) % 512;
    end
    if (ld) m_mode = mv;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic load(int mv);
    cyc(1, mv, 0, 0, 0, 0, 0);
  endtask

  task automatic burst(bit wr, int c, int beats);
    cyc(0, 0, 1, wr, c, 0, 0);
    for (int i = 0; i < beats; i++) cyc(0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check_outputs();
    rst_ni = 1'b1;
    @(negedge clk);
    check_outputs();

    cur_req = "R4";                       // len 8 sequential, upper bits kept
    load(8'h33); burst(0, 9'h1F5, 9);
    cur_req = "R5";                       // len 8 interleaved
    load(8'h3B); burst(0, 5, 9); burst(1, 9'h0AE, 9);
    cur_req = "R3";                       // lengths 4, 2, 1 and a reserved code
    load(8'h32); burst(0, 9'h0E6, 5);
    load(8'h31); burst(0, 9'h013, 3);
    load(8'h30); burst(0, 9'h100, 2);
    load(8'h34); burst(0, 9'h077, 2);
    load(8'h36); burst(1, 9'h078, 2);
    cur_req = "R7";                       // full page with interleaved is illegal
    load(8'h3F); burst(0, 9'h1FE, 2);
    cur_req = "R6";                       // full page wraps 511 -> 0 and never ends
    load(8'h37); burst(0, 9'h1FE, 600);
    cur_req = "R10";
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cur_req = "R8";                       // single write: writes 1 beat, reads keep 8
    load(8'hB3); burst(1, 9'h042, 3); burst(0, 9'h042, 9);
    cur_req = "R12";                      // holds without advance; idle advance ignored
    load(8'h32);
    cyc(0, 0, 1, 0, 9'h11D, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    cur_req = "R11";                      // restart mid burst, with stop and adv together
    load(8'h33);
    cyc(0, 0, 1, 0, 9'h004, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 9'h0F1, 1, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    cur_req = "R9";
    burst(0, 9'h007, 8);
    cur_req = "R13";                      // CAS 2, load and start in same cycle
    load(8'h23);
    cyc(1, 8'h31, 1, 0, 9'h010, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    burst(0, 9'h010, 2);

    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 8) == 0, int'($urandom % 256), ($urandom % 6) == 0,
          1'($urandom), int'($urandom % 512), ($urandom % 4) != 0,
          ($urandom % 16) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule